// File: doc/BRIEF.md
# Lockable Service Watchdog

This block is a down-counting watchdog meant to sit behind a host register. The counter steps once per slow tick, a single-cycle clock-enable pulse at 32 Hz. When it runs out, the block latches an expiry flag and can raise an interrupt request. The host keeps the watchdog from expiring by writing a reload ("kick") bit before the count reaches zero. The kick reloads the counter from the stored period.

The same write also carries a lock bit, which is stored with every write. While the stored lock is set, the period field of any later write is discarded. This lets software kick the watchdog without any risk of changing the period. A stored period of zero switches the watchdog off. The expiry flag stays set until the host reads its flags register, which reaches the block as a one-cycle read-clear pulse. The tick source and the interrupt pin driver are outside the block.

Top module: `wdt_lockable`

## Requirements
- R1: After reset the readback is all zero (period 0, lock 0), and the flag and the interrupt request are low.
- R2: A write while the stored lock is 0 stores bits [5:0] of the write word as the period. The readback shows the period in [5:0], 0 in bit 6 and the lock in bit 7.
- R3: Storing a nonzero period loads the counter at once. With no further writes, the flag rises on the edge that takes in the N-th tick after the write, where N is the period.
- R4: A write with bit 6 set reloads the counter from the stored period, so N further ticks are needed from that write.
- R5: Bit 7 of every write is stored as the lock. While the stored lock is 1, the period field of a write has no effect on the period or the counter. A write with bit 7 clear unlocks the block for the writes that follow it.
- R6: The counter moves only on cycles with the tick enable high. The flag never rises on a cycle without a tick.
- R7: After expiry the counter stays at zero. The flag stays set through further ticks, and once cleared it does not return until the counter is reloaded.
- R8: A read-clear pulse clears the flag on the next edge. If expiry occurs in the same cycle as the pulse, expiry wins and the flag stays set.
- R9: While the stored period is 0, no number of ticks or kicks sets the flag.
- R10: The interrupt request is high exactly when the flag is set and the interrupt enable input is high.
- R11: A write that loads the counter in the same cycle as a tick takes priority, and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | 32 Hz step enable, one clock cycle wide |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Write word: [5:0] period, [6] kick, [7] lock |
| rd_clr_i | input | 1 | Flag read-clear pulse |
| irq_en_i | input | 1 | Interrupt request enable |
| reg_q_o | output | 8 | Readback: [5:0] period, [6] zero, [7] lock |
| flag_o | output | 1 | Expiry flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Writes, ticks and read-clear pulses all act on the first clock edge after they are applied, so the readback and the flag are due one edge later. The interrupt request follows the enable input in the same cycle. The bench drives each stimulus on a falling edge and queues the expected result as that rising edge occurs. The monitor compares 1 ns after the rising edge. Each expectation therefore refers to exactly one edge, and multi-tick expiry windows are counted tick by tick.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   // offsets of the control bits above the period field
   localparam int WDT_KICK_OFS = 0;
   localparam int WDT_LOCK_OFS = 1;

   typedef enum logic [1:0] {
      WDT_OFF     = 2'd0,
      WDT_RUN     = 2'd1,
      WDT_EXPIRED = 2'd2
   } wdt_state_e;

endpackage

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg #(
   parameter int TO_W = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [TO_W-1:0] wr_period,
   input  logic            wr_lock,
   output logic [TO_W-1:0] period_q,
   output logic            lock_q,
   output logic            accept
);

   // the period field is taken only when the lock stored by earlier writes is clear
   assign accept = wr_en && !lock_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         period_q <= '0;
         lock_q   <= 1'b0;
      end else if (wr_en) begin
         if (!lock_q)
            period_q <= wr_period;
         lock_q <= wr_lock;
      end
   end

   assert_locked_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && lock_q) |=> $stable(period_q));

endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter
   import wdt_pkg::*;
#(
   parameter int TO_W     = 6,
   parameter int PRESCALE = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            load,
   input  logic [TO_W-1:0] load_val,
   input  logic [TO_W-1:0] period,
   output logic            expire
);

   logic [TO_W-1:0] count;
   logic            step;
   wdt_state_e      state;

   generate
      if (PRESCALE == 1) begin : g_direct
         assign step = tick;
      end else begin : g_prescale
         localparam int PW = $clog2(PRESCALE);
         localparam logic [PW-1:0] PLAST = PW'(PRESCALE - 1);
         logic [PW-1:0] pre;
         always_ff @(posedge clk) begin
            if (!rst_n || load)
               pre <= '0;
            else if (tick)
               pre <= (pre == PLAST) ? '0 : pre + 1'b1;
         end
         assign step = tick && (pre == PLAST);
      end
   endgenerate

   always_comb begin
      if (period == '0)
         state = WDT_OFF;
      else if (count == '0)
         state = WDT_EXPIRED;
      else
         state = WDT_RUN;
   end

   assign expire = (state == WDT_RUN) && step && !load && (count == TO_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n)
         count <= '0;
      else if (load)
         count <= load_val;
      else if (state == WDT_RUN && step)
         count <= count - 1'b1;
   end

   assert_moves_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !load) |=> $stable(count));

   assert_holds_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && !load) |=> (count == '0));

endmodule

// File: rtl/wdt_flag.sv
module wdt_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic flag
);

   always_ff @(posedge clk) begin
      if (!rst_n)
         flag <= 1'b0;
      else if (set)
         flag <= 1'b1;
      else if (clr)
         flag <= 1'b0;
   end

   assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> flag);

   assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !flag);

endmodule

// File: rtl/wdt_lockable.sv
module wdt_lockable
   import wdt_pkg::*;
#(
   parameter int TO_W     = 6,
   parameter int PRESCALE = 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick_i,
   input  logic            wr_en_i,
   input  logic [TO_W+1:0] wr_data_i,
   input  logic            rd_clr_i,
   input  logic            irq_en_i,
   output logic [TO_W+1:0] reg_q_o,
   output logic            flag_o,
   output logic            irq_o
);

   localparam int KICK_BIT = TO_W + WDT_KICK_OFS;
   localparam int LOCK_BIT = TO_W + WDT_LOCK_OFS;

   initial begin
      assert_param_width: assert (TO_W >= 1 && TO_W <= 16)
         else $error("TO_W out of range");
      assert_param_prescale: assert (PRESCALE >= 1)
         else $error("PRESCALE must be at least 1");
   end

   logic [TO_W-1:0] period_q;
   logic            lock_q;
   logic            accept;
   logic            load;
   logic [TO_W-1:0] load_val;
   logic            expire;

   wdt_cfg_reg #(.TO_W(TO_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en_i),
      .wr_period(wr_data_i[TO_W-1:0]),
      .wr_lock  (wr_data_i[LOCK_BIT]),
      .period_q (period_q),
      .lock_q   (lock_q),
      .accept   (accept)
   );

   // an accepted period write loads the new value; a kick reloads the kept one
   assign load     = accept || (wr_en_i && wr_data_i[KICK_BIT]);
   assign load_val = accept ? wr_data_i[TO_W-1:0] : period_q;

   wdt_down_counter #(.TO_W(TO_W), .PRESCALE(PRESCALE)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick_i),
      .load    (load),
      .load_val(load_val),
      .period  (period_q),
      .expire  (expire)
   );

   wdt_flag u_flag (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (expire),
      .clr  (rd_clr_i),
      .flag (flag_o)
   );

   assign reg_q_o = {lock_q, 1'b0, period_q};
   assign irq_o   = flag_o && irq_en_i;

   assert_rise_needs_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_o) |-> $past(tick_i));

   assert_off_is_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (period_q == '0 && !wr_en_i) |=> !$rose(flag_o));

   assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (irq_en_i && flag_o));

endmodule

// File: tb/wdt_lockable_test.sv
`timescale 1ns/1ps
module wdt_lockable_test;
   localparam int TW = 6;
   localparam int DW = TW + 2;

   typedef struct {
      logic          flag;
      logic          irq;
      logic [DW-1:0] regv;
      string         tag;
   } exp_t;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic          rst_n = 1'b0;
   logic          tick = 1'b0, wr_en = 1'b0, rd_clr = 1'b0, irq_en = 1'b0;
   logic          ien_cfg = 1'b1;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] reg_q;
   logic          flag, irq;

   exp_t q[$];
   int   n_chk = 0, n_fail = 0;
   bit   done = 1'b0;

   wdt_lockable #(.TO_W(TW), .PRESCALE(1)) uut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
      .wr_data_i(wr_data), .rd_clr_i(rd_clr), .irq_en_i(irq_en),
      .reg_q_o(reg_q), .flag_o(flag), .irq_o(irq)
   );

   // driver: apply one cycle of stimulus, queue the result due after that edge
   task automatic step(input logic tk, input logic we, input logic [DW-1:0] d,
                       input logic rc, input bit chk, input string tag,
                       input logic ef, input logic ei, input logic [DW-1:0] er);
      @(negedge clk);
      tick = tk; wr_en = we; wr_data = d; rd_clr = rc; irq_en = ien_cfg;
      @(posedge clk);
      if (chk) q.push_back('{ef, ei, er, tag});
   endtask

   task automatic ticks(input int n, input string tag, input logic ef,
                        input logic ei, input logic [DW-1:0] er);
      for (int i = 0; i < n; i++) step(1, 0, '0, 0, 1, tag, ef, ei, er);
   endtask

   // monitor: compare 1 ns after each rising edge
   initial begin
      forever begin
         exp_t e;
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            e = q.pop_front();
            n_chk++;
            if (flag !== e.flag || irq !== e.irq || reg_q !== e.regv) begin
               n_fail++;
               $display("FAIL %s: flag=%b irq=%b reg=%h expected flag=%b irq=%b reg=%h",
                        e.tag, flag, irq, reg_q, e.flag, e.irq, e.regv);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not finish, got hang expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      // R1 reset state
      step(0, 0, '0, 0, 1, "R1", 0, 0, 8'h00);
      // R2 store period 3; R3 expiry on third tick; R6 idle cycle
      step(0, 1, 8'h03, 0, 1, "R2", 0, 0, 8'h03);
      step(1, 0, '0, 0, 1, "R3", 0, 0, 8'h03);
      step(0, 0, '0, 0, 1, "R6", 0, 0, 8'h03);
      step(1, 0, '0, 0, 1, "R3", 0, 0, 8'h03);
      step(1, 0, '0, 0, 1, "R3", 1, 1, 8'h03);
      ticks(5, "R7", 1, 1, 8'h03);
      step(0, 0, '0, 1, 1, "R8", 0, 0, 8'h03);
      ticks(4, "R7", 0, 0, 8'h03);
      // R5 lock with period 5, R4 kick while locked ignores period 1
      step(0, 1, 8'h85, 0, 1, "R5", 0, 0, 8'h85);
      ticks(4, "R4", 0, 0, 8'h85);
      step(0, 1, 8'hC1, 0, 1, "R5", 0, 0, 8'h85);
      ticks(4, "R4", 0, 0, 8'h85);
      step(1, 0, '0, 1, 1, "R8", 1, 1, 8'h85);
      step(0, 0, '0, 1, 1, "R8", 0, 0, 8'h85);
      // R5 unlocking write keeps the period; the next write is taken
      step(0, 1, 8'h02, 0, 1, "R5", 0, 0, 8'h05);
      ticks(3, "R5", 0, 0, 8'h05);
      step(0, 1, 8'h02, 0, 1, "R2", 0, 0, 8'h02);
      step(1, 0, '0, 0, 1, "R3", 0, 0, 8'h02);
      step(1, 0, '0, 0, 1, "R3", 1, 1, 8'h02);
      step(0, 0, '0, 1, 1, "R8", 0, 0, 8'h02);
      // R11 write together with a tick
      step(1, 1, 8'h03, 0, 1, "R11", 0, 0, 8'h03);
      ticks(2, "R11", 0, 0, 8'h03);
      step(1, 0, '0, 0, 1, "R11", 1, 1, 8'h03);
      step(0, 0, '0, 1, 1, "R8", 0, 0, 8'h03);
      // R10 interrupt gating
      ien_cfg = 1'b0;
      step(0, 1, 8'h01, 0, 1, "R10", 0, 0, 8'h01);
      step(1, 0, '0, 0, 1, "R10", 1, 0, 8'h01);
      ien_cfg = 1'b1;
      step(0, 0, '0, 0, 1, "R10", 1, 1, 8'h01);
      step(0, 0, '0, 1, 1, "R8", 0, 0, 8'h01);
      // R9 period zero disables, kick too
      step(0, 1, 8'h00, 0, 1, "R9", 0, 0, 8'h00);
      ticks(70, "R9", 0, 0, 8'h00);
      step(0, 1, 8'h40, 0, 1, "R9", 0, 0, 8'h00);
      ticks(70, "R9", 0, 0, 8'h00);
      // R6 no progress without ticks
      step(0, 1, 8'h02, 0, 1, "R6", 0, 0, 8'h02);
      for (int i = 0; i < 20; i++) step(0, 0, '0, 0, 1, "R6", 0, 0, 8'h02);
      step(1, 0, '0, 0, 1, "R6", 0, 0, 8'h02);
      step(1, 0, '0, 0, 1, "R6", 1, 1, 8'h02);
      step(0, 0, '0, 0, 0, "", 0, 0, '0);
      repeat (3) @(posedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule